// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small programmable logic array. It takes a group of native product terms and one borrowed input that has already been summed by a neighbouring cell. It ORs them together and passes the sum through a polarity XOR set by configuration. The result either bypasses storage as combinational logic or feeds a one-bit register. At run time the register can behave as a D, T, JK or SR flip-flop. An output selector picks the registered or the combinational value. That value drives the cell's pin and also returns to the array as feedback.

The register changes state only in a system-clock cycle in which its chosen clock source has a rising edge. The source is either an external clock input or a clock product term. A preset product term and a clear built from up to two product terms act on the register asynchronously. A host processor can write the register from a single bit of its data bus and can read the register back on that same bit. The bit lane is a parameter that comes from the cell's position within its port. The cell holds a native group of 3 terms in one port and 4 in the other; this is also a parameter.

Top module: `omc_cell`

## Requirements
- R1: With `cfg_out_sel`=0 the pin equals (OR of all `pt_native` bits OR `pt_borrow`) XOR `cfg_invert`, with no clock delay. This value is the logic term L.
- R2: With `cfg_out_sel`=1 the pin shows the register state. `fb_out` always equals `pin_out`.
- R3: D mode (`cfg_ff_type`=2'b00): on a clock tick the register takes L. Between ticks it holds.
- R4: T mode (`cfg_ff_type`=2'b01): on a clock tick the register inverts when L=1 and holds when L=0.
- R5: JK mode (`cfg_ff_type`=2'b10): J is L and K is the OR of `pt_aux`. On a tick, J=1,K=0 sets the register; J=0,K=1 clears it; J=K=1 toggles it; J=K=0 holds it.
- R6: SR mode (`cfg_ff_type`=2'b11): S is L and R is the OR of `pt_aux`. On a tick, S=1,R=0 sets the register and S=0,R=1 clears it. S=R=0 and S=R=1 both hold.
- R7: A tick is a rising edge of `clk` in which the selected source is 1 and was 0 at the previous rising edge. `cfg_clk_sel`=0 selects `ext_clk` and 1 selects `pt_clk`. The source that is not selected has no effect.
- R8: Either bit of `pt_clr` forces the register to 0 at once, without waiting for `clk`. `pt_pre` forces it to 1 at once. When both are asserted, clear wins.
- R9: `cpu_load`=1 at a rising edge of `clk` writes `cpu_data[BIT_IDX]` into the register. A logic-path tick in the same cycle is overridden.
- R10: While `cpu_rd`=1, `rd_data` carries the register state at bit BIT_IDX and 0 on every other bit, whatever `cfg_out_sel` is. While `cpu_rd`=0, `rd_data` is all zeros.
- R11: `rst_n`=0 at a rising edge of `clk` clears the register and the clock-edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_native | input | NATIVE_PT | Native product terms |
| pt_borrow | input | 1 | Borrowed terms, already summed |
| pt_aux | input | AUX_PT | K / R product-term group |
| pt_clk | input | 1 | Clock product term |
| ext_clk | input | 1 | External clock input |
| pt_pre | input | 1 | Preset product term, active high |
| pt_clr | input | CLR_PT | Clear product terms, ORed, active high |
| cfg_ff_type | input | 2 | Register type: 00 D, 01 T, 10 JK, 11 SR |
| cfg_invert | input | 1 | Polarity XOR control |
| cfg_clk_sel | input | 1 | 0 external clock, 1 clock product term |
| cfg_out_sel | input | 1 | 0 combinational, 1 registered |
| cpu_load | input | 1 | Host write strobe |
| cpu_rd | input | 1 | Host read strobe |
| cpu_data | input | BUS_W | Host write data |
| rd_data | output | BUS_W | Host read data |
| pin_out | output | 1 | Port pin drive |
| fb_out | output | 1 | Feedback to the array |

## Verification
The assertions take it that the configuration inputs stay constant while the register is in use. They also take it that preset and clear are released only after a clock cycle in which they were sampled, and that no clear or preset overlaps a host load they are meant to check. The stimulus changes inputs only just after a rising edge of `clk`. It changes the configuration only while both clock sources are low, and it holds every asynchronous preset or clear for at least one full cycle before releasing it.

// File: rtl/omc_pkg.sv
// Package omc_pkg: shared types for the output macrocell.
// Assumes: register-type encoding is fixed as listed below.
package omc_pkg;

    typedef enum logic [1:0] {
        KIND_D  = 2'b00,
        KIND_T  = 2'b01,
        KIND_JK = 2'b10,
        KIND_SR = 2'b11
    } ff_kind_t;

endpackage

// File: rtl/omc_term_sum.sv
// Module omc_term_sum: sums the native and borrowed product terms, applies
// the polarity XOR, and sums the auxiliary (K/R) group.
// Assumes: the borrowed input has already been ORed by its source cell.
module omc_term_sum #(
    parameter int NATIVE_PT = 3,
    parameter int AUX_PT    = 2
) (
    input  logic [NATIVE_PT-1:0] pt_native,
    input  logic                 pt_borrow,
    input  logic [AUX_PT-1:0]    pt_aux,
    input  logic                 cfg_invert,
    output logic                 logic_term,
    output logic                 aux_term
);

    logic sum_raw;

    // Main sum: OR of every native term plus the borrowed sum.
    always_comb begin
        sum_raw = pt_borrow;
        for (int i = 0; i < NATIVE_PT; i++) begin
            sum_raw = sum_raw | pt_native[i];
        end
    end

    // Polarity stage ahead of both the register and the bypass path.
    always_comb begin
        logic_term = sum_raw ^ cfg_invert;
    end

    // Second group feeds K in JK mode and R in SR mode.
    always_comb begin
        aux_term = |pt_aux;
    end

endmodule

// File: rtl/omc_clk_edge.sv
// Module omc_clk_edge: chooses the register clock source and turns its rising
// edges into one-cycle tick pulses in the system-clock domain.
// Assumes: each source is slow against clk and stays high or low for at
// least one clk period.
module omc_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic pt_clk,
    input  logic cfg_clk_sel,
    output logic tick
);

    logic src_now;
    logic src_prev;

    // Source selection: 0 picks the external clock, 1 the product-term clock.
    always_comb begin
        src_now = cfg_clk_sel ? pt_clk : ext_clk;
    end

    // Records the source level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev <= 1'b0;
        end else begin
            src_prev <= src_now;
        end
    end

    // A rising edge is a high level now after a low one at the last edge.
    always_comb begin
        tick = src_now & ~src_prev;
    end

endmodule

// File: rtl/omc_ff_core.sv
// Module omc_ff_core: the configurable one-bit register. It works out the
// next state for D, T, JK or SR behaviour, applies asynchronous preset and
// clear (clear first), then reset, host load, then the logic-path tick.
// Assumes: preset and clear come glitch-free from the array.
module omc_ff_core #(
    parameter int CLR_PT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  omc_pkg::ff_kind_t kind,
    input  logic              term_a,
    input  logic              term_b,
    input  logic              tick,
    input  logic              pt_pre,
    input  logic [CLR_PT-1:0] pt_clr,
    input  logic              load_en,
    input  logic              load_bit,
    output logic              q
);

    import omc_pkg::*;

    logic clr_any;
    logic next_q;

    // Clear may be built from several product terms.
    always_comb begin
        clr_any = |pt_clr;
    end

    // Next state for the selected register type.
    always_comb begin
        unique case (kind)
            KIND_D:  next_q = term_a;
            KIND_T:  next_q = q ^ term_a;
            KIND_JK: begin
                case ({term_a, term_b})
                    2'b10:   next_q = 1'b1;
                    2'b01:   next_q = 1'b0;
                    2'b11:   next_q = ~q;
                    default: next_q = q;
                endcase
            end
            KIND_SR: begin
                case ({term_a, term_b})
                    2'b10:   next_q = 1'b1;
                    2'b01:   next_q = 1'b0;
                    default: next_q = q;
                endcase
            end
            default: next_q = q;
        endcase
    end

    // State register with asynchronous clear and preset.
    always_ff @(posedge clk or posedge clr_any or posedge pt_pre) begin
        if (clr_any) begin
            q <= 1'b0;
        end else if (pt_pre) begin
            q <= 1'b1;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else if (load_en) begin
            q <= load_bit;
        end else if (tick) begin
            q <= next_q;
        end
    end

endmodule

// File: rtl/omc_bus_lane.sv
// Module omc_bus_lane: ties the register to one bit lane of the host bus,
// picking the write bit and placing the read bit.
// Assumes: BIT_IDX is below BUS_W.
module omc_bus_lane #(
    parameter int BUS_W   = 8,
    parameter int BIT_IDX = 0
) (
    input  logic [BUS_W-1:0] cpu_data,
    input  logic             cpu_rd,
    input  logic             q,
    output logic             load_bit,
    output logic [BUS_W-1:0] rd_data
);

    // Write side: only this cell's lane is used.
    always_comb begin
        load_bit = cpu_data[BIT_IDX];
    end

    // Read side: the register goes out on its lane, every other lane is zero.
    always_comb begin
        for (int i = 0; i < BUS_W; i++) begin
            rd_data[i] = (i == BIT_IDX) ? (cpu_rd & q) : 1'b0;
        end
    end

endmodule

// File: rtl/omc_cell.sv
// Module omc_cell: top of the output macrocell. It joins the term sum, the
// clock-edge picker, the register and the bus lane, and drives the pin and
// feedback through the output selector.
// Assumes: configuration inputs are static while the cell is in use.
module omc_cell #(
    parameter int NATIVE_PT = 3,
    parameter int AUX_PT    = 2,
    parameter int CLR_PT    = 2,
    parameter int BUS_W     = 8,
    parameter int BIT_IDX   = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NATIVE_PT-1:0] pt_native,
    input  logic                 pt_borrow,
    input  logic [AUX_PT-1:0]    pt_aux,
    input  logic                 pt_clk,
    input  logic                 ext_clk,
    input  logic                 pt_pre,
    input  logic [CLR_PT-1:0]    pt_clr,
    input  logic [1:0]           cfg_ff_type,
    input  logic                 cfg_invert,
    input  logic                 cfg_clk_sel,
    input  logic                 cfg_out_sel,
    input  logic                 cpu_load,
    input  logic                 cpu_rd,
    input  logic [BUS_W-1:0]     cpu_data,
    output logic [BUS_W-1:0]     rd_data,
    output logic                 pin_out,
    output logic                 fb_out
);

    import omc_pkg::*;

    logic     logic_term;
    logic     aux_term;
    logic     tick;
    logic     load_bit;
    logic     reg_q;
    ff_kind_t kind;

    // Convert the raw configuration field to the register-type enum.
    always_comb begin
        kind = ff_kind_t'(cfg_ff_type);
    end

    omc_term_sum #(
        .NATIVE_PT (NATIVE_PT),
        .AUX_PT    (AUX_PT)
    ) u_sum (
        .pt_native  (pt_native),
        .pt_borrow  (pt_borrow),
        .pt_aux     (pt_aux),
        .cfg_invert (cfg_invert),
        .logic_term (logic_term),
        .aux_term   (aux_term)
    );

    omc_clk_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk     (ext_clk),
        .pt_clk      (pt_clk),
        .cfg_clk_sel (cfg_clk_sel),
        .tick        (tick)
    );

    omc_ff_core #(
        .CLR_PT (CLR_PT)
    ) u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .term_a   (logic_term),
        .term_b   (aux_term),
        .tick     (tick),
        .pt_pre   (pt_pre),
        .pt_clr   (pt_clr),
        .load_en  (cpu_load),
        .load_bit (load_bit),
        .q        (reg_q)
    );

    omc_bus_lane #(
        .BUS_W   (BUS_W),
        .BIT_IDX (BIT_IDX)
    ) u_lane (
        .cpu_data (cpu_data),
        .cpu_rd   (cpu_rd),
        .q        (reg_q),
        .load_bit (load_bit),
        .rd_data  (rd_data)
    );

    // Output selector: registered or combinational onto the pin and feedback.
    always_comb begin
        pin_out = cfg_out_sel ? reg_q : logic_term;
        fb_out  = pin_out;
    end

endmodule

// File: rtl/omc_cell_chk.sv
// Module omc_cell_chk: property checks for omc_cell, attached by bind.
// Assumes: the configuration is static and preset/clear are held for a cycle.
module omc_cell_chk #(
    parameter int NATIVE_PT = 3,
    parameter int CLR_PT    = 2,
    parameter int BUS_W     = 8,
    parameter int BIT_IDX   = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NATIVE_PT-1:0] pt_native,
    input logic                 pt_borrow,
    input logic                 pt_pre,
    input logic [CLR_PT-1:0]    pt_clr,
    input logic                 cfg_invert,
    input logic                 cfg_out_sel,
    input logic                 cpu_load,
    input logic                 cpu_rd,
    input logic [BUS_W-1:0]     cpu_data,
    input logic [BUS_W-1:0]     rd_data,
    input logic                 pin_out,
    input logic                 fb_out,
    input logic                 reg_q
);

    // R1
    bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_out_sel |-> pin_out == ((|pt_native | pt_borrow) ^ cfg_invert));

    // R2
    reg_on_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out_sel |-> (pin_out == reg_q && fb_out == pin_out));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pt_clr) |-> !reg_q);

    // R8
    preset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_pre && !(|pt_clr)) |-> reg_q);

    // R9
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_load && !pt_pre && !(|pt_clr)) |=>
            ((reg_q == $past(cpu_data[BIT_IDX])) || pt_pre || (|pt_clr)));

    // R10
    read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == (cpu_rd ? (BUS_W'(reg_q) << BIT_IDX) : '0));

endmodule

bind omc_cell omc_cell_chk #(
    .NATIVE_PT (NATIVE_PT),
    .CLR_PT    (CLR_PT),
    .BUS_W     (BUS_W),
    .BIT_IDX   (BIT_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pt_native   (pt_native),
    .pt_borrow   (pt_borrow),
    .pt_pre      (pt_pre),
    .pt_clr      (pt_clr),
    .cfg_invert  (cfg_invert),
    .cfg_out_sel (cfg_out_sel),
    .cpu_load    (cpu_load),
    .cpu_rd      (cpu_rd),
    .cpu_data    (cpu_data),
    .rd_data     (rd_data),
    .pin_out     (pin_out),
    .fb_out      (fb_out),
    .reg_q       (reg_q)
);

// File: tb/omc_cell_bench.sv
// Bench for omc_cell: a table of bypass-path vectors, then directed tests.
module omc_cell_bench;

    localparam int NATIVE_PT = 3;
    localparam int AUX_PT    = 2;
    localparam int CLR_PT    = 2;
    localparam int BUS_W     = 8;
    localparam int BIT_IDX   = 5;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NATIVE_PT-1:0] pt_native;
    logic                 pt_borrow;
    logic [AUX_PT-1:0]    pt_aux;
    logic                 pt_clk;
    logic                 ext_clk;
    logic                 pt_pre;
    logic [CLR_PT-1:0]    pt_clr;
    logic [1:0]           cfg_ff_type;
    logic                 cfg_invert;
    logic                 cfg_clk_sel;
    logic                 cfg_out_sel;
    logic                 cpu_load;
    logic                 cpu_rd;
    logic [BUS_W-1:0]     cpu_data;
    logic [BUS_W-1:0]     rd_data;
    logic                 pin_out;
    logic                 fb_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    omc_cell #(
        .NATIVE_PT (NATIVE_PT),
        .AUX_PT    (AUX_PT),
        .CLR_PT    (CLR_PT),
        .BUS_W     (BUS_W),
        .BIT_IDX   (BIT_IDX)
    ) u_omc_cell (
        .clk (clk), .rst_n (rst_n), .pt_native (pt_native),
        .pt_borrow (pt_borrow), .pt_aux (pt_aux), .pt_clk (pt_clk),
        .ext_clk (ext_clk), .pt_pre (pt_pre), .pt_clr (pt_clr),
        .cfg_ff_type (cfg_ff_type), .cfg_invert (cfg_invert),
        .cfg_clk_sel (cfg_clk_sel), .cfg_out_sel (cfg_out_sel),
        .cpu_load (cpu_load), .cpu_rd (cpu_rd), .cpu_data (cpu_data),
        .rd_data (rd_data), .pin_out (pin_out), .fb_out (fb_out)
    );

    // Bypass vectors: {invert, native[2:0], borrow, expected pin}
    localparam logic [5:0] BYP_VEC [10] = '{
        6'b0_000_0_0, 6'b0_001_0_1, 6'b0_010_0_1, 6'b0_100_0_1,
        6'b0_000_1_1, 6'b0_111_1_1, 6'b1_000_0_1, 6'b1_010_0_0,
        6'b1_000_1_0, 6'b1_101_1_0
    };

    task automatic check(input string req, input logic [BUS_W-1:0] act,
                         input logic [BUS_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One rising and falling edge of the external clock source.
    task automatic ext_pulse();
        ext_clk = 1'b1;
        step();
        ext_clk = 1'b0;
        step();
    endtask

    // Clear the register through the asynchronous clear, held one cycle.
    task automatic force_clear();
        pt_clr = 2'b01;
        step();
        pt_clr = 2'b00;
        step();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pt_native = '0; pt_borrow = 1'b0; pt_aux = '0;
        pt_clk = 1'b0; ext_clk = 1'b0; pt_pre = 1'b0; pt_clr = '0;
        cfg_ff_type = 2'b00; cfg_invert = 1'b0; cfg_clk_sel = 1'b0;
        cfg_out_sel = 1'b1; cpu_load = 1'b0; cpu_rd = 1'b0; cpu_data = '0;
        #1;
        step();
        step();
        // R11: reset state
        check("R11 reset q", 8'(pin_out), 8'h0);
        check("R10 idle read", rd_data, 8'h00);
        rst_n = 1'b1;
        step();

        // R1: bypass table
        cfg_out_sel = 1'b0;
        foreach (BYP_VEC[i]) begin
            cfg_invert = BYP_VEC[i][5];
            pt_native  = BYP_VEC[i][4:2];
            pt_borrow  = BYP_VEC[i][1];
            #1;
            check("R1 bypass", 8'(pin_out), 8'(BYP_VEC[i][0]));
            check("R2 feedback", 8'(fb_out), 8'(pin_out));
        end
        cfg_invert = 1'b0; pt_native = '0; pt_borrow = 1'b0;
        cfg_out_sel = 1'b1;
        step();

        // R3 / R7: D mode, external clock
        pt_native = 3'b001;
        step(); step();
        check("R7 no tick holds", 8'(pin_out), 8'h0);
        ext_pulse();
        check("R3 D takes 1", 8'(pin_out), 8'h1);
        check("R2 feedback reg", 8'(fb_out), 8'h1);
        pt_native = 3'b000;
        ext_pulse();
        check("R3 D takes 0", 8'(pin_out), 8'h0);
        pt_native = 3'b001;
        pt_clk = 1'b1; step(); pt_clk = 1'b0; step();
        check("R7 unselected pt_clk ignored", 8'(pin_out), 8'h0);
        cfg_clk_sel = 1'b1;
        step();
        ext_pulse();
        check("R7 unselected ext_clk ignored", 8'(pin_out), 8'h0);
        pt_clk = 1'b1; step(); pt_clk = 1'b0; step();
        check("R7 pt_clk ticks", 8'(pin_out), 8'h1);
        cfg_clk_sel = 1'b0;
        step();

        // R8: asynchronous clear, no clock edge needed
        pt_clr = 2'b10;
        #1;
        check("R8 async clear", 8'(pin_out), 8'h0);
        step();
        pt_clr = 2'b00;
        step();

        // R4: T mode
        cfg_ff_type = 2'b01; pt_native = 3'b010;
        ext_pulse();
        check("R4 T toggle to 1", 8'(pin_out), 8'h1);
        ext_pulse();
        check("R4 T toggle to 0", 8'(pin_out), 8'h0);
        pt_native = 3'b000;
        ext_pulse();
        check("R4 T hold", 8'(pin_out), 8'h0);

        // R5: JK mode
        cfg_ff_type = 2'b10;
        pt_native = 3'b100; pt_aux = 2'b00; ext_pulse();
        check("R5 JK set", 8'(pin_out), 8'h1);
        pt_native = 3'b000; ext_pulse();
        check("R5 JK hold", 8'(pin_out), 8'h1);
        pt_aux = 2'b10; ext_pulse();
        check("R5 JK clear", 8'(pin_out), 8'h0);
        pt_native = 3'b001; pt_aux = 2'b01; ext_pulse();
        check("R5 JK toggle up", 8'(pin_out), 8'h1);
        ext_pulse();
        check("R5 JK toggle down", 8'(pin_out), 8'h0);

        // R6: SR mode
        cfg_ff_type = 2'b11;
        pt_native = 3'b001; pt_aux = 2'b00; ext_pulse();
        check("R6 SR set", 8'(pin_out), 8'h1);
        pt_aux = 2'b11; ext_pulse();
        check("R6 SR both hold 1", 8'(pin_out), 8'h1);
        pt_native = 3'b000; pt_aux = 2'b01; ext_pulse();
        check("R6 SR reset", 8'(pin_out), 8'h0);
        pt_native = 3'b010; pt_aux = 2'b10; ext_pulse();
        check("R6 SR both hold 0", 8'(pin_out), 8'h0);
        pt_aux = 2'b00;

        // R1 polarity into D register
        cfg_ff_type = 2'b00; pt_native = 3'b000; cfg_invert = 1'b1;
        ext_pulse();
        check("R1 inverted into D", 8'(pin_out), 8'h1);
        cfg_invert = 1'b0;
        force_clear();

        // R8: preset, then clear wins over preset
        pt_pre = 1'b1;
        #1;
        check("R8 async preset", 8'(pin_out), 8'h1);
        step();
        pt_clr = 2'b01;
        #1;
        check("R8 clear beats preset", 8'(pin_out), 8'h0);
        step();
        pt_pre = 1'b0; pt_clr = 2'b00;
        step();

        // R9: host load beats a same-cycle tick
        pt_native = 3'b001;
        cpu_data = 8'b1101_1111;
        cpu_load = 1'b1; ext_clk = 1'b1;
        step();
        cpu_load = 1'b0; ext_clk = 1'b0;
        check("R9 load wins over tick", 8'(pin_out), 8'h0);
        step();
        cpu_data = 8'b0010_0000; cpu_load = 1'b1;
        step();
        cpu_load = 1'b0;
        check("R9 load lane bit 1", 8'(pin_out), 8'h1);

        // R10: read lane independent of output select
        cfg_out_sel = 1'b0; pt_native = 3'b000; cpu_rd = 1'b1;
        #1;
        check("R10 read lane", rd_data, 8'h20);
        cpu_rd = 1'b0;
        #1;
        check("R10 no read zero", rd_data, 8'h00);
        cfg_out_sel = 1'b1;

        // R11: reset mid-operation
        rst_n = 1'b0;
        step();
        check("R11 reset clears q", 8'(pin_out), 8'h0);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule